// File: doc/BRIEF.md
# UART register and flag unit

This block is the software-visible face of one UART channel. It decodes a small 16-bit register bus into four word registers: a control register, a write-only transmit data register, a read-only receive data register and a status register. It keeps a one-byte transmit buffer, a receive FIFO that is two bytes deep by default, and a set of status flags. Each flag follows its own clear rule: write-1-to-clear, cleared when the receive data is read, cleared when the transmit data is written, or driven by hardware only.

On the engine side the block talks to a transmit/receive engine that it does not contain. That engine signals with one-cycle strobes when it takes the buffered byte, when it finishes sending, when it delivers a received byte, and when it sees a framing or parity error. It also supplies two busy levels. The block holds a byte for the engine until the engine takes it. It tells the engine when the channel is enabled and when a software reset is under way. A single interrupt request is the OR of the seven flag bits.

Register word addresses are CTRL=0, TXD=1, RXD=2 and STAT=3. A register is read combinationally while `rd_i` is high. The read side effects take place at the clock edge on which `rd_i` is high.

Top module: `uart_regfile`

## Requirements
- R1: After the asynchronous reset, CTRL reads 0x0000, STAT reads 0x0001 (only the transmit-buffer-empty flag set, with both busy inputs low), and `irq_o` is 1.
- R2: CTRL bit 0 is a read/write enable that resets to 0. While it is 0, every engine strobe is ignored: no byte enters the FIFO, no flag changes and `eng_tx_valid_o` stays low.
- R3: Writing 1 to CTRL bit 1 starts a software reset. Bit 1 then reads 1 for SRST_CYCLES cycles and clears itself. The reset returns all flags to their reset values and empties the FIFO. It leaves the enable bit unchanged. Writing 0 to bit 1 does nothing.
- R4: A write to TXD loads bits 7:0 onto `eng_tx_data_o` and clears STAT bit 0. `eng_tx_valid_o` is high while the channel is enabled and the buffer is full. `eng_tx_taken_i` sets STAT bit 0 again. TXD reads as 0.
- R5: Reading RXD returns the oldest stored byte in bits 7:0, with bits 15:8 at 0, and removes that byte. Reading RXD while the FIFO is empty returns 0.
- R6: STAT bit 1 is high while the FIFO holds at least one byte. STAT bit 2 is high while the FIFO is full.
- R7: A byte that arrives while the FIFO is full, and is not matched by a read in the same cycle, is dropped and sets STAT bit 3 (overrun). A 1 written to bit 3 clears it. A byte that arrives in the same cycle as a read of a full FIFO is stored, and no overrun is flagged.
- R8: STAT bit 5 (framing error) and bit 4 (parity error) are set by their strobes. Each is cleared by writing 1 to its bit or by any read of RXD. A set in the same cycle as a clear leaves the flag set.
- R9: STAT bit 6 (transmission end) is set by `eng_tx_end_i` and cleared by writing 1 to it. A set in the same cycle as a clear leaves it set.
- R10: STAT bit 8 mirrors `eng_tx_busy_i` and bit 9 mirrors `eng_rx_busy_i`. A write to STAT changes nothing except the clearing of bits 3 to 6.
- R11: `irq_o` equals the OR of STAT bits 6:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register word address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe (triggers read side effects) |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, combinational on addr_i |
| eng_en_o | output | 1 | Channel enabled |
| eng_srst_o | output | 1 | Software reset in progress |
| eng_tx_valid_o | output | 1 | Transmit buffer holds a byte for the engine |
| eng_tx_data_o | output | 8 | Buffered transmit byte |
| eng_tx_taken_i | input | 1 | Engine has taken the buffered byte |
| eng_tx_end_i | input | 1 | Engine has finished transmitting |
| eng_rx_valid_i | input | 1 | Received byte strobe |
| eng_rx_data_i | input | 8 | Received byte |
| eng_frame_err_i | input | 1 | Framing error strobe |
| eng_parity_err_i | input | 1 | Parity error strobe |
| eng_tx_busy_i | input | 1 | Transmitter busy level |
| eng_rx_busy_i | input | 1 | Receiver busy level |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions check the following on every cycle. The FIFO count never goes above its depth, and a dropped byte leaves a full FIFO unchanged. A software-reset request is followed by the busy indication and by flags at their reset values. A transmit-data write clears the buffer-empty flag. An error strobe wins over a clear in the same cycle. Only the bench's scenarios can show the rest. That covers the FIFO ordering, read side effects seen through the bus, the push-and-pop-in-one-cycle case at full, the length of the self-clearing reset, the enable being kept across it, and the engine strobes being ignored while the channel is disabled.

// File: rtl/uart_reg_pkg.sv
package uart_reg_pkg;
  localparam int unsigned REG_W  = 16;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    ADR_CTRL = 2'd0,
    ADR_TXD  = 2'd1,
    ADR_RXD  = 2'd2,
    ADR_STAT = 2'd3
  } reg_adr_e;

  // control bits
  localparam int unsigned C_EN   = 0;
  localparam int unsigned C_SRST = 1;

  // status bits
  localparam int unsigned S_TBE  = 0;
  localparam int unsigned S_RB1  = 1;
  localparam int unsigned S_RB2  = 2;
  localparam int unsigned S_OE   = 3;
  localparam int unsigned S_PE   = 4;
  localparam int unsigned S_FE   = 5;
  localparam int unsigned S_TEND = 6;
  localparam int unsigned S_TBSY = 8;
  localparam int unsigned S_RBSY = 9;

  typedef struct packed {
    logic tend;
    logic fe;
    logic pe;
    logic oe;
    logic tbe;
  } flag_t;

  localparam flag_t FLAG_RST = '{tend: 1'b0, fe: 1'b0, pe: 1'b0, oe: 1'b0, tbe: 1'b1};
endpackage

// File: rtl/uart_ctrl.sv
module uart_ctrl #(
  parameter int unsigned SRST_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic en_wdata_i,
  input  logic srst_wdata_i,
  output logic en_o,
  output logic srst_req_o,
  output logic srst_busy_o
);
  localparam int unsigned CNT_W = $clog2(SRST_CYCLES + 1);

  logic             en_q;
  logic [CNT_W-1:0] cnt_q;

  assign srst_req_o  = wr_i & srst_wdata_i;
  assign srst_busy_o = (cnt_q != '0);
  assign en_o        = en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      if (wr_i) en_q <= en_wdata_i;
      if (srst_req_o)           cnt_q <= CNT_W'(SRST_CYCLES);
      else if (cnt_q != '0)     cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assert_srst_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_req_o |=> srst_busy_o);
  assert_srst_selfclr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(srst_busy_o) |-> !$past(srst_req_o));
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int unsigned DEPTH = 2,
  parameter int unsigned W     = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o,
  output logic         full_o,
  output logic         drop_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] rd_q, wr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_pop, do_push;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign do_pop  = pop_i & ~empty_o;
  assign do_push = push_i & (~full_o | do_pop);
  assign drop_o  = push_i & full_o & ~do_pop;
  assign dout_o  = empty_o ? '0 : mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_pop)  rd_q <= nxt(rd_q);
      if (do_push) wr_q <= nxt(wr_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + CNT_W'(1);
      else if (do_pop && !do_push) cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem_q[wr_q] <= din_i;
  end

  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  assert_drop_keeps_full_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_o && !flush_i) |=> full_o);
endmodule

// File: rtl/uart_flags.sv
module uart_flags
  import uart_reg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       txd_wr_i,
  input  logic       tx_taken_i,
  input  logic       tx_end_i,
  input  logic       rx_drop_i,
  input  logic       fe_set_i,
  input  logic       pe_set_i,
  input  logic       rxd_rd_i,
  input  logic       w1c_i,
  input  logic [3:0] w1c_mask_i,  // {tend, fe, pe, oe}
  output flag_t      flags_o
);
  flag_t f_q;
  logic  clr_oe, clr_pe, clr_fe, clr_tend;

  assign clr_oe   = w1c_i & w1c_mask_i[0];
  assign clr_pe   = (w1c_i & w1c_mask_i[1]) | rxd_rd_i;
  assign clr_fe   = (w1c_i & w1c_mask_i[2]) | rxd_rd_i;
  assign clr_tend = w1c_i & w1c_mask_i[3];
  assign flags_o  = f_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      f_q <= FLAG_RST;
    end else if (clr_i) begin
      f_q <= FLAG_RST;
    end else begin
      if (txd_wr_i)        f_q.tbe  <= 1'b0;
      else if (tx_taken_i) f_q.tbe  <= 1'b1;
      if (rx_drop_i)       f_q.oe   <= 1'b1;
      else if (clr_oe)     f_q.oe   <= 1'b0;
      if (pe_set_i)        f_q.pe   <= 1'b1;
      else if (clr_pe)     f_q.pe   <= 1'b0;
      if (fe_set_i)        f_q.fe   <= 1'b1;
      else if (clr_fe)     f_q.fe   <= 1'b0;
      if (tx_end_i)        f_q.tend <= 1'b1;
      else if (clr_tend)   f_q.tend <= 1'b0;
    end
  end

  assert_tbe_clr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txd_wr_i && !clr_i) |=> !f_q.tbe);
  assert_srst_flags_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (f_q == FLAG_RST));
  assert_err_set_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((fe_set_i || pe_set_i) && !clr_i) |=> (f_q.fe || !$past(fe_set_i)) && (f_q.pe || !$past(pe_set_i)));
  assert_oe_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_drop_i && !clr_i) |=> f_q.oe);
endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
  import uart_reg_pkg::*;
#(
  parameter int unsigned SRST_CYCLES = 4,
  parameter int unsigned RX_DEPTH    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              eng_en_o,
  output logic              eng_srst_o,
  output logic              eng_tx_valid_o,
  output logic [BYTE_W-1:0] eng_tx_data_o,
  input  logic              eng_tx_taken_i,
  input  logic              eng_tx_end_i,
  input  logic              eng_rx_valid_i,
  input  logic [BYTE_W-1:0] eng_rx_data_i,
  input  logic              eng_frame_err_i,
  input  logic              eng_parity_err_i,
  input  logic              eng_tx_busy_i,
  input  logic              eng_rx_busy_i,
  output logic              irq_o
);
  logic wr_ctrl, wr_txd, wr_stat, rd_rxd;
  logic en, srst_req, srst_busy, srst_clr, ev_ok;
  logic fifo_empty, fifo_full, fifo_drop;
  logic [BYTE_W-1:0] fifo_dout, txd_q;
  logic [REG_W-1:0]  stat;
  flag_t flags;
  logic unused_wdata;

  assign unused_wdata = ^wdata_i[REG_W-1:BYTE_W];

  assign wr_ctrl  = wr_i & (addr_i == ADR_CTRL);
  assign wr_txd   = wr_i & (addr_i == ADR_TXD);
  assign wr_stat  = wr_i & (addr_i == ADR_STAT);
  assign rd_rxd   = rd_i & (addr_i == ADR_RXD);
  assign srst_clr = srst_req | srst_busy;
  assign ev_ok    = en & ~srst_clr;

  uart_ctrl #(.SRST_CYCLES(SRST_CYCLES)) i_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (wr_ctrl),
    .en_wdata_i   (wdata_i[C_EN]),
    .srst_wdata_i (wdata_i[C_SRST]),
    .en_o         (en),
    .srst_req_o   (srst_req),
    .srst_busy_o  (srst_busy)
  );

  uart_rx_fifo #(.DEPTH(RX_DEPTH), .W(BYTE_W)) i_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (srst_clr),
    .push_i  (eng_rx_valid_i & ev_ok),
    .din_i   (eng_rx_data_i),
    .pop_i   (rd_rxd),
    .dout_o  (fifo_dout),
    .empty_o (fifo_empty),
    .full_o  (fifo_full),
    .drop_o  (fifo_drop)
  );

  uart_flags i_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (srst_clr),
    .txd_wr_i   (wr_txd),
    .tx_taken_i (eng_tx_taken_i & ev_ok),
    .tx_end_i   (eng_tx_end_i & ev_ok),
    .rx_drop_i  (fifo_drop),
    .fe_set_i   (eng_frame_err_i & ev_ok),
    .pe_set_i   (eng_parity_err_i & ev_ok),
    .rxd_rd_i   (rd_rxd),
    .w1c_i      (wr_stat),
    .w1c_mask_i (wdata_i[S_TEND:S_OE]),
    .flags_o    (flags)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     txd_q <= '0;
    else if (wr_txd) txd_q <= wdata_i[BYTE_W-1:0];
  end

  always_comb begin
    stat         = '0;
    stat[S_TBE]  = flags.tbe;
    stat[S_RB1]  = ~fifo_empty;
    stat[S_RB2]  = fifo_full;
    stat[S_OE]   = flags.oe;
    stat[S_PE]   = flags.pe;
    stat[S_FE]   = flags.fe;
    stat[S_TEND] = flags.tend;
    stat[S_TBSY] = eng_tx_busy_i;
    stat[S_RBSY] = eng_rx_busy_i;
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (addr_i)
        ADR_CTRL: begin
          rdata_o[C_EN]   = en;
          rdata_o[C_SRST] = srst_busy;
        end
        ADR_RXD:  rdata_o[BYTE_W-1:0] = fifo_dout;
        ADR_STAT: rdata_o = stat;
        default:  rdata_o = '0;
      endcase
    end
  end

  assign eng_en_o       = en;
  assign eng_srst_o     = srst_clr;
  assign eng_tx_valid_o = en & ~flags.tbe & ~srst_busy;
  assign eng_tx_data_o  = txd_q;
  assign irq_o          = |stat[S_TEND:S_TBE];

  assert_disabled_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && !wr_i && !rd_i) |=> $stable(stat[S_TEND:S_TBE]));
endmodule

// File: tb/test_uart_regfile.sv
module test_uart_regfile;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  addr_i = '0;
  logic        wr_i = 1'b0, rd_i = 1'b0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        eng_en_o, eng_srst_o, eng_tx_valid_o, irq_o;
  logic [7:0]  eng_tx_data_o;
  logic        eng_tx_taken_i = 0, eng_tx_end_i = 0, eng_rx_valid_i = 0;
  logic [7:0]  eng_rx_data_i = '0;
  logic        eng_frame_err_i = 0, eng_parity_err_i = 0;
  logic        eng_tx_busy_i = 0, eng_rx_busy_i = 0;

  localparam int SRST_N = 4;

  uart_regfile #(.SRST_CYCLES(SRST_N), .RX_DEPTH(2)) i_uart_regfile (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .eng_en_o(eng_en_o), .eng_srst_o(eng_srst_o),
    .eng_tx_valid_o(eng_tx_valid_o), .eng_tx_data_o(eng_tx_data_o),
    .eng_tx_taken_i(eng_tx_taken_i), .eng_tx_end_i(eng_tx_end_i),
    .eng_rx_valid_i(eng_rx_valid_i), .eng_rx_data_i(eng_rx_data_i),
    .eng_frame_err_i(eng_frame_err_i), .eng_parity_err_i(eng_parity_err_i),
    .eng_tx_busy_i(eng_tx_busy_i), .eng_rx_busy_i(eng_rx_busy_i), .irq_o(irq_o)
  );

  always #5 clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0;
  logic [7:0] m_q[$];
  logic m_en = 0, m_tbe = 1, m_oe = 0, m_pe = 0, m_fe = 0, m_tend = 0;
  logic [7:0] m_txd = '0;

  function automatic logic [15:0] exp_stat();
    logic [15:0] s = '0;
    s[0] = m_tbe; s[1] = (m_q.size() >= 1); s[2] = (m_q.size() == 2);
    s[3] = m_oe; s[4] = m_pe; s[5] = m_fe; s[6] = m_tend;
    s[8] = eng_tx_busy_i; s[9] = eng_rx_busy_i;
    return s;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk_i); addr_i = a; wdata_i = d; wr_i = 1;
    @(negedge clk_i); wr_i = 0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk_i); addr_i = a; rd_i = 1; #1 d = rdata_o;
    @(negedge clk_i); rd_i = 0;
  endtask

  task automatic rx_byte(input logic [7:0] b, input logic fe, input logic pe);
    @(negedge clk_i); eng_rx_valid_i = 1; eng_rx_data_i = b;
    eng_frame_err_i = fe; eng_parity_err_i = pe;
    @(negedge clk_i); eng_rx_valid_i = 0; eng_frame_err_i = 0; eng_parity_err_i = 0;
    if (m_en) begin
      if (m_q.size() < 2) m_q.push_back(b); else m_oe = 1;
      m_fe |= fe; m_pe |= pe;
    end
  endtask

  task automatic rd_rxd(input string req);
    logic [15:0] d;
    logic [15:0] e;
    e = (m_q.size() != 0) ? {8'h00, m_q[0]} : 16'h0000;
    bus_rd(2'd2, d);
    chk(req, d, e);
    if (m_q.size() != 0) void'(m_q.pop_front());
    m_fe = 0; m_pe = 0;
  endtask

  task automatic w1c(input logic [15:0] m);
    bus_wr(2'd3, m);
    if (m[3]) m_oe = 0;
    if (m[4]) m_pe = 0;
    if (m[5]) m_fe = 0;
    if (m[6]) m_tend = 0;
  endtask

  task automatic wr_txd(input logic [15:0] d);
    bus_wr(2'd1, d);
    m_tbe = 0; m_txd = d[7:0];
    chk("R4 txd", {7'd0, eng_tx_valid_o, eng_tx_data_o}, {7'd0, m_en, m_txd});
  endtask

  task automatic strobe_taken();
    @(negedge clk_i); eng_tx_taken_i = 1;
    @(negedge clk_i); eng_tx_taken_i = 0;
    if (m_en) m_tbe = 1;
  endtask

  task automatic strobe_tend();
    @(negedge clk_i); eng_tx_end_i = 1;
    @(negedge clk_i); eng_tx_end_i = 0;
    if (m_en) m_tend = 1;
  endtask

  task automatic chk_stat(input string req);
    logic [15:0] d;
    logic [15:0] e;
    e = exp_stat();
    bus_rd(2'd3, d);
    chk(req, d, e);
    chk("R11 irq", {15'd0, irq_o}, {15'd0, |e[6:0]});
  endtask

  initial begin
    #(10 * 150000);
    n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] d;
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);

    // R1 reset state
    bus_rd(2'd0, d); chk("R1 ctrl", d, 16'h0000);
    chk_stat("R1 stat");
    chk("R1 irq", {15'd0, irq_o}, 16'h0001);

    // R2 disabled: strobes ignored
    rx_byte(8'h11, 1, 1); strobe_tend(); strobe_taken();
    chk_stat("R2 disabled");
    chk("R2 txvalid", {15'd0, eng_tx_valid_o}, 16'h0000);
    bus_wr(2'd0, 16'h0001); m_en = 1;
    bus_rd(2'd0, d); chk("R2 enable", d, 16'h0001);

    // R5 R6 R7 fill, overflow, order
    rx_byte(8'hA1, 0, 0); chk_stat("R6 one byte");
    rx_byte(8'hB2, 0, 0); chk_stat("R6 two bytes");
    rx_byte(8'hC3, 0, 0); chk_stat("R7 overrun");
    rd_rxd("R5 first"); rd_rxd("R5 second"); rd_rxd("R5 empty");
    chk_stat("R6 drained");
    w1c(16'h0008); chk_stat("R7 w1c");

    // R8 error flags
    rx_byte(8'h33, 1, 0); chk_stat("R8 fe set");
    rd_rxd("R8 rd"); chk_stat("R8 fe rd clr");
    rx_byte(8'h44, 0, 1); chk_stat("R8 pe set");
    w1c(16'h0010); chk_stat("R8 pe w1c");
    @(negedge clk_i); eng_frame_err_i = 1; addr_i = 2'd3; wdata_i = 16'h0020; wr_i = 1;
    @(negedge clk_i); eng_frame_err_i = 0; wr_i = 0; m_fe = 1;
    chk_stat("R8 set wins");
    rd_rxd("R8 rd2");

    // R9 transmission end
    strobe_tend(); chk_stat("R9 set");
    w1c(16'h0040); chk_stat("R9 w1c");
    @(negedge clk_i); eng_tx_end_i = 1; addr_i = 2'd3; wdata_i = 16'h0040; wr_i = 1;
    @(negedge clk_i); eng_tx_end_i = 0; wr_i = 0; m_tend = 1;
    chk_stat("R9 set wins");

    // R4 transmit buffer
    wr_txd(16'hFF5A); chk_stat("R4 tbe clr");
    bus_rd(2'd1, d); chk("R4 txd read", d, 16'h0000);
    strobe_taken(); chk_stat("R4 taken");
    chk("R4 valid low", {15'd0, eng_tx_valid_o}, 16'h0000);

    // R10 busy mirrors, status write
    eng_tx_busy_i = 1; eng_rx_busy_i = 1;
    rx_byte(8'h55, 0, 0);
    chk_stat("R10 busy");
    w1c(16'hFFFF); chk_stat("R10 write all");
    eng_tx_busy_i = 0;
    chk_stat("R10 txbusy off");
    eng_rx_busy_i = 0;

    // R7 push and pop in one cycle at full
    rx_byte(8'h66, 0, 0);
    @(negedge clk_i); addr_i = 2'd2; rd_i = 1; eng_rx_valid_i = 1; eng_rx_data_i = 8'h77;
    #1 chk("R5 pop at full", rdata_o, {8'h00, m_q[0]});
    @(negedge clk_i); rd_i = 0; eng_rx_valid_i = 0;
    void'(m_q.pop_front()); m_q.push_back(8'h77); m_fe = 0; m_pe = 0;
    chk_stat("R7 no overrun");
    rd_rxd("R5 after swap a"); rd_rxd("R5 after swap b");

    // R3 soft reset
    strobe_tend();
    bus_wr(2'd0, 16'h0001); chk_stat("R3 write0 no effect");
    rx_byte(8'h88, 1, 0); wr_txd(16'h0099);
    bus_wr(2'd0, 16'h0003);
    bus_rd(2'd0, d); chk("R3 busy", d, 16'h0003);
    repeat (SRST_N + 2) @(negedge clk_i);
    bus_rd(2'd0, d); chk("R3 selfclr", d, 16'h0001);
    m_q.delete(); m_tbe = 1; m_oe = 0; m_pe = 0; m_fe = 0; m_tend = 0;
    chk_stat("R3 flags");
    rd_rxd("R3 flushed");

    // random mix
    for (int i = 0; i < 300; i++) begin
      int op;
      op = $urandom_range(0, 5);
      case (op)
        0, 1: rx_byte(8'($urandom), ($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0));
        2: rd_rxd("R5 rand");
        3: w1c(16'($urandom));
        4: if ($urandom_range(0, 1) == 1) wr_txd(16'($urandom)); else strobe_taken();
        default: strobe_tend();
      endcase
      chk_stat("R6 rand");
    end

    // R2 disable again
    bus_wr(2'd0, 16'h0000); m_en = 0;
    rx_byte(8'hEE, 1, 1); strobe_tend();
    chk_stat("R2 disabled again");
    chk("R2 txvalid off", {15'd0, eng_tx_valid_o}, 16'h0000);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule